// File: doc/BRIEF.md
# Palette Pixel Pipeline

This block converts a stream of 8-bit pixel indices into 18-bit colors, one pixel per pixel-clock cycle. On every rising edge it captures an index and a blank flag. The index is ANDed with a pixel mask and then used to address a palette of 256 entries held in external synchronous storage. The block returns three 6-bit channel codes, red, green and blue, which feed external converters.

A blank flag travels through the pipeline next to the index. When the flag is set, the three channels of that pixel come out as zero, whatever the index and whatever the palette holds. Every pixel, blanked or not, reaches the outputs after the same fixed latency. The pixel mask is a register that reset sets to all ones. A write strobe can replace its value.

The palette storage sits outside the block and answers through a read-only port. The block drives a registered address. The storage must return the addressed word on the next rising edge. The processor path that fills the palette is not part of this block.

Top module: `palette_pixel_pipe`

## Requirements
- R1: While reset is high, all three channel outputs and the palette address are zero. On the first three rising edges after reset goes low, the channel outputs stay zero.
- R2: A pixel captured at rising edge N appears on the channel outputs right after rising edge N+3. A new pixel can be accepted on every edge with no bubbles.
- R3: The palette word is split as red = bits [17:12], green = bits [11:6] and blue = bits [5:0]. Each channel output carries its own field unchanged.
- R4: A pixel captured with blank high produces zero on all three channels, whatever its index. Blanking uses the same three-edge latency, so a blanked pixel never affects the pixels on either side of it.
- R5: The palette address equals the captured index ANDed with the mask value. It is registered one edge after capture, and the storage returns that word one edge later.
- R6: Reset sets the pixel mask to all ones (0xFF). After reset, indices therefore reach the palette unmodified.
- R7: A mask write made with the strobe high at edge N applies to pixels captured from edge N+1 onward. The pixel captured at edge N still uses the old mask. Without the strobe, the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pix_idx | input | 8 | Pixel palette index |
| pix_blank | input | 1 | Blank flag for this pixel |
| mask_we | input | 1 | Load strobe for the pixel mask |
| mask_val | input | 8 | New pixel mask value |
| pal_raddr | output | 8 | Palette read address (masked index) |
| pal_rdata | input | 18 | Palette word, returned one edge after the address |
| red_o | output | 6 | Red channel code |
| grn_o | output | 6 | Green channel code |
| blu_o | output | 6 | Blue channel code |

## Verification
The hardest case to reach is the boundary where the pipeline fills right after reset. Here the reset values of the internal stages and the first real pixel sit next to each other. The bench releases reset with a non-blank pixel already on the inputs. It then expects zeros on exactly the first three edges and that pixel's color on the fourth. A mask write is driven in the same cycle as a pixel, to show that the old mask still applies to that pixel. Blank is toggled cycle by cycle with the index held, so that any misalignment between the blank and color paths shows up.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int unsigned NUM_CH = 3;

  // Field order inside a palette word, lowest field first
  typedef enum logic [1:0] {
    CH_BLU = 2'd0,
    CH_GRN = 2'd1,
    CH_RED = 2'd2
  } chan_e;
endpackage

// File: rtl/pxl_mask_reg.sv
module pxl_mask_reg #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] val,
  output logic [IDX_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '1;
    else if (we) mask_q <= val;
  end
endmodule

// File: rtl/pxl_index_stage.sv
module pxl_index_stage #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             blank,
  input  logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] addr_q,
  output logic             blank_q
);
  // First stage: capture and mask; the address feeds the palette port directly
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      blank_q <= 1'b1;
    end else begin
      addr_q  <= idx & mask;
      blank_q <= blank;
    end
  end
endmodule

// File: rtl/pxl_color_stage.sv
module pxl_color_stage #(
  parameter int unsigned CH_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  blank_in,
  input  logic [pxl_pkg::NUM_CH*CH_W-1:0]       rdata,
  output logic [pxl_pkg::NUM_CH-1:0][CH_W-1:0]  ch_o
);
  localparam int unsigned COL_W = pxl_pkg::NUM_CH * CH_W;

  logic             blank_d2;  // aligned with the palette read
  logic             blank_d3;  // aligned with the captured word
  logic [COL_W-1:0] color_d3;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_d2 <= 1'b1;
      blank_d3 <= 1'b1;
      color_d3 <= '0;
    end else begin
      blank_d2 <= blank_in;
      blank_d3 <= blank_d2;
      color_d3 <= rdata;
    end
  end

  for (genvar c = 0; c < pxl_pkg::NUM_CH; c++) begin : g_ch
    logic [CH_W-1:0] out_q;
    always_ff @(posedge clk) begin
      if (rst)           out_q <= '0;
      else if (blank_d3) out_q <= '0;
      else               out_q <= color_d3[c*CH_W +: CH_W];
    end
    assign ch_o[c] = out_q;
  end
endmodule

// File: rtl/palette_pixel_pipe.sv
module palette_pixel_pipe #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [IDX_W-1:0]                   pix_idx,
  input  logic                               pix_blank,
  input  logic                               mask_we,
  input  logic [IDX_W-1:0]                   mask_val,
  output logic [IDX_W-1:0]                   pal_raddr,
  input  logic [pxl_pkg::NUM_CH*CH_W-1:0]    pal_rdata,
  output logic [CH_W-1:0]                    red_o,
  output logic [CH_W-1:0]                    grn_o,
  output logic [CH_W-1:0]                    blu_o
);
  logic [IDX_W-1:0]                     mask_q;
  logic                                 blank_s1;
  logic [pxl_pkg::NUM_CH-1:0][CH_W-1:0] ch;

  pxl_mask_reg #(.IDX_W(IDX_W)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we     (mask_we),
    .val    (mask_val),
    .mask_q (mask_q)
  );

  pxl_index_stage #(.IDX_W(IDX_W)) u_index (
    .clk     (clk),
    .rst     (rst),
    .idx     (pix_idx),
    .blank   (pix_blank),
    .mask    (mask_q),
    .addr_q  (pal_raddr),
    .blank_q (blank_s1)
  );

  pxl_color_stage #(.CH_W(CH_W)) u_color (
    .clk      (clk),
    .rst      (rst),
    .blank_in (blank_s1),
    .rdata    (pal_rdata),
    .ch_o     (ch)
  );

  assign red_o = ch[pxl_pkg::CH_RED];
  assign grn_o = ch[pxl_pkg::CH_GRN];
  assign blu_o = ch[pxl_pkg::CH_BLU];
endmodule

// File: rtl/pxl_pipe_checker.sv
module pxl_pipe_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CH_W  = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic [IDX_W-1:0]                 pix_idx,
  input logic                             pix_blank,
  input logic                             mask_we,
  input logic [IDX_W-1:0]                 mask_val,
  input logic [IDX_W-1:0]                 pal_raddr,
  input logic [pxl_pkg::NUM_CH*CH_W-1:0]  pal_rdata,
  input logic [CH_W-1:0]                  red_o,
  input logic [CH_W-1:0]                  grn_o,
  input logic [CH_W-1:0]                  blu_o,
  input logic [IDX_W-1:0]                 mask_q
);
  localparam int unsigned COL_W = pxl_pkg::NUM_CH * CH_W;

  // Edges since reset release, saturating; gates the history-based properties
  logic [2:0] run_cnt = '0;
  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (red_o == '0 && grn_o == '0 && blu_o == '0 && pal_raddr == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd4 && !$past(pix_blank, 4)) |-> red_o == $past(pal_rdata[COL_W-1 -: CH_W], 2));

  p_packing_r3: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd4 && !$past(pix_blank, 4)) |->
      (grn_o == $past(pal_rdata[2*CH_W-1 -: CH_W], 2) && blu_o == $past(pal_rdata[CH_W-1:0], 2)));

  p_blank_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd4 && $past(pix_blank, 4)) |-> (red_o == '0 && grn_o == '0 && blu_o == '0));

  p_addr_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd1) |-> pal_raddr == ($past(pix_idx) & $past(mask_q)));

  p_mask_default_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mask_q == '1);

  p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd1 && $past(mask_we)) |-> mask_q == $past(mask_val));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd1 && !$past(mask_we)) |-> $stable(mask_q));
endmodule

bind palette_pixel_pipe pxl_pipe_checker #(.IDX_W(IDX_W), .CH_W(CH_W)) u_pxl_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_idx   (pix_idx),
  .pix_blank (pix_blank),
  .mask_we   (mask_we),
  .mask_val  (mask_val),
  .pal_raddr (pal_raddr),
  .pal_rdata (pal_rdata),
  .red_o     (red_o),
  .grn_o     (grn_o),
  .blu_o     (blu_o),
  .mask_q    (mask_q)
);

// File: tb/test_palette_pixel_pipe.sv
module test_palette_pixel_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pix_idx = '0;
  logic        pix_blank = 1'b1;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_val = '0;
  logic [7:0]  pal_raddr;
  logic [17:0] pal_rdata = '0;
  logic [5:0]  red_o, grn_o, blu_o;

  always #4 clk = ~clk;

  palette_pixel_pipe i_palette_pixel_pipe (
    .clk(clk), .rst(rst), .pix_idx(pix_idx), .pix_blank(pix_blank),
    .mask_we(mask_we), .mask_val(mask_val), .pal_raddr(pal_raddr),
    .pal_rdata(pal_rdata), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
  );

  // Palette storage model: synchronous read, one edge of latency
  logic [17:0] mem [256];
  always @(posedge clk) pal_rdata <= mem[pal_raddr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [17:0] val;
    string       tag;
  } exp_t;

  exp_t col_q[$];
  exp_t adr_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [7:0] mask_m = 8'hFF;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp_v);
    end
  endtask

  // Monitor: compares the scoreboard heads when their edge has passed
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (col_q.size() > 0 && col_q[0].due == cyc) begin
        e = col_q.pop_front();
        check(e.tag, {red_o, grn_o, blu_o}, e.val);
      end
      if (adr_q.size() > 0 && adr_q[0].due == cyc) begin
        e = adr_q.pop_front();
        check("R5", {10'd0, pal_raddr}, e.val);
      end
    end
  end

  function automatic logic [17:0] color_of(input logic [7:0] idx, input logic blank);
    return blank ? 18'd0 : mem[idx & mask_m];
  endfunction

  // Driver: one pixel per negedge, with an optional mask write in the same cycle
  task automatic pix_mw(input logic [7:0] idx, input logic blank, input logic we,
                        input logic [7:0] val, input string tag);
    @(negedge clk);
    pix_idx   = idx;
    pix_blank = blank;
    mask_we   = we;
    mask_val  = val;
    col_q.push_back('{cyc + 4, color_of(idx, blank), tag});
    adr_q.push_back('{cyc + 1, {10'd0, idx & mask_m}, "R5"});
    if (we) mask_m = val;
  endtask

  task automatic pix(input logic [7:0] idx, input logic blank, input string tag);
    pix_mw(idx, blank, 1'b0, 8'h00, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pix_blank = 1'b1;
      mask_we   = 1'b0;
    end
  endtask

  // Reset with a live pixel on the inputs, then release and track the fill
  task automatic do_reset(input logic [7:0] first_idx);
    @(negedge clk);
    rst = 1'b1;
    pix_idx = 8'h5A;
    pix_blank = 1'b0;
    mask_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #2;
      check("R1", {red_o, grn_o, blu_o, 8'd0} >> 8, 18'd0);
      check("R1", {10'd0, pal_raddr}, 18'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    mask_m = 8'hFF;
    pix_idx = first_idx;
    pix_blank = 1'b0;
    for (int k = 1; k <= 3; k++) col_q.push_back('{cyc + k, 18'd0, "R1"});
    col_q.push_back('{cyc + 4, mem[first_idx], "R6"});
    adr_q.push_back('{cyc + 1, {10'd0, first_idx}, "R5"});
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {6'((i * 7 + 3) & 63), 6'((i * 13 + 5) & 63), 6'((i ^ 42) & 63)};

    do_reset(8'hB7);

    // R2/R3: sweep every palette entry back to back
    for (int i = 0; i < 256; i++) pix(8'(i), 1'b0, (i < 128) ? "R2" : "R3");

    // R4: blank interleaved, index kept moving
    for (int i = 0; i < 40; i++) pix(8'(i * 37 + 11), (i % 3) == 0, ((i % 3) == 0) ? "R4" : "R2");
    // R4: toggle blank every cycle with a fixed index
    for (int i = 0; i < 12; i++) pix(8'hE9, i[0], "R4");

    // R7: a mask write affects only later pixels; R5: masked lookups
    pix_mw(8'hC3, 1'b0, 1'b1, 8'h0F, "R7");
    pix(8'hC3, 1'b0, "R7");
    for (int i = 0; i < 8; i++) pix(8'(i * 29 + 200), 1'b0, "R5");
    pix_mw(8'h9C, 1'b0, 1'b1, 8'hF0, "R7");
    for (int i = 0; i < 8; i++) pix(8'(i * 17 + 3), 1'b0, "R5");
    pix_mw(8'h77, 1'b0, 1'b1, 8'h00, "R7");
    for (int i = 0; i < 4; i++) pix(8'(i * 61 + 1), 1'b0, "R5");
    pix_mw(8'h77, 1'b1, 1'b1, 8'hAA, "R4");
    for (int i = 0; i < 8; i++) pix(8'(i * 33 + 5), 1'b0, "R7");

    // R6: mid-run reset brings the mask back to all ones
    pix_mw(8'h10, 1'b0, 1'b1, 8'h03, "R7");
    idle(6);
    do_reset(8'hFE);
    for (int i = 0; i < 16; i++) pix(8'(i * 15 + 8), 1'b0, "R6");

    idle(8);
    n_cmp++;
    if (col_q.size() != 0 || adr_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending results actual=%0d expected=0", col_q.size() + adr_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule